// File: doc/BRIEF.md
# Address Break Comparator

This unit sits beside a processor's bus and compares each qualified bus cycle against a programmed break condition. Software loads a break address, a break data word and a control byte. The control byte chooses the kind of cycle to catch: instruction fetch, data read, data write, or either data direction. It also chooses the access width and whether the data value takes part in the comparison. When one strobed cycle meets every selected condition, a sticky break flag is set. The unit then drives a break request while the flag and the enable bit are both high. No global interrupt mask acts on this request.

The data comparison follows the bus lanes. A byte access always carries its value on the upper 8-bit lane, at even and at odd addresses. A byte match therefore compares that lane with the upper half of the data register. For a word access, the address selects the lanes. An even address compares all 16 bits. An odd address compares only the lower lane with the lower half of the register.

Software works through a small read/write register port with a two-bit select. The flag can only be cleared deliberately. Software must first read it as 1 and then write 0 to it. A new match that arrives in the same cycle as the clear keeps the flag set.

Top module: `abrk_unit`

## Requirements
- R1: After reset the control register, the break address, the flag and the enable read as 0, and `brk_irq` is 0. The data register has no reset value.
- R2: `reg_sel` selects the register: 0 is control (8 bits, upper bits read 0), 1 is status (bit 0 enable, bit 1 flag), 2 is break address, 3 is break data. `reg_rdata` shows the selected register in the same cycle. A write with `reg_we` takes effect at the next clock edge.
- R3: Control bits [7:6] select the cycle kind. 2'b10 is instruction fetch (`bus_fetch`=1). 2'b00 is data read (`bus_fetch`=0, `bus_write`=0). 2'b01 is data write (`bus_fetch`=0, `bus_write`=1). 2'b11 is any data access (`bus_fetch`=0).
- R4: Control bits [5:4] select the size. 2'b01 accepts only byte cycles (`bus_word`=0). 2'b10 accepts only word cycles. 2'b00 and 2'b11 accept both.
- R5: A byte cycle's address must equal the break address exactly. A word cycle's address is compared with bit 0 ignored.
- R6: When data compare is on, a byte cycle compares `bus_data[15:8]` with the upper byte of the data register, at even and odd addresses. The lower lane is ignored.
- R7: When data compare is on, a word cycle at an even address compares all 16 bits. A word cycle at an odd address compares `bus_data[7:0]` with the lower byte of the data register.
- R8: Control bit 3 enables data compare. When it is 0, the data value never prevents a match.
- R9: The flag is set at the clock edge that ends a cycle with `bus_stb`=1 only if address, data, kind and size all match. Without the strobe, or with any one condition failing, the flag stays 0.
- R10: The flag is sticky. Writing 0 to status bit 1 clears it only after software has read status with the flag at 1. Writing 1 to that bit never sets it.
- R11: A match in the same cycle as a valid clear leaves the flag set.
- R12: `brk_irq` is 1 exactly while the flag and the enable are both 1. No mask input exists.
- R13: Control value 0x80 breaks on an instruction fetch at the break address of either size, whatever the data. A data read at that address does not break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_stb | input | 1 | One-cycle qualifier marking the sampled bus cycle |
| bus_addr | input | 16 | Bus address |
| bus_data | input | 16 | Bus data, upper lane [15:8], lower lane [7:0] |
| bus_fetch | input | 1 | Cycle is an instruction fetch |
| bus_write | input | 1 | Cycle is a write (data cycles) |
| bus_word | input | 1 | 1 for word access, 0 for byte access |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| brk_irq | output | 1 | Break request, not maskable |

## Verification
The hardest state to reach from the ports is a clear that is legal in every respect and still loses to a new match. The flag must be set, software must have read it as 1, and a matching strobed cycle must arrive in exactly the cycle that carries the zero write. The bench first sets the flag and reads it. At a single falling edge it then drives both the matching bus cycle and the status write. Afterwards it observes `brk_irq` to confirm that the flag survived. The lane rules are reached through table vectors in which the data value sits on the wrong lane, or sits at an odd address, while the address and kind still match.

// File: rtl/abrk_pkg.sv
package abrk_pkg;
    typedef enum logic [1:0] {
        TY_READ  = 2'b00,
        TY_WRITE = 2'b01,
        TY_FETCH = 2'b10,
        TY_RDWR  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        SZ_ANY   = 2'b00,
        SZ_BYTE  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_ANYB  = 2'b11
    } acc_size_e;

    typedef struct packed {
        acc_kind_e  kind;
        acc_size_e  size;
        logic       dcmp;
        logic [2:0] rsvd;
    } ctrl_t;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_ADDR = 2'd2;
    localparam logic [1:0] SEL_DATA = 2'd3;

    localparam int STAT_EN_BIT   = 0;
    localparam int STAT_FLAG_BIT = 1;
endpackage

// File: rtl/abrk_match.sv
module abrk_match
    import abrk_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  ctrl_t          ctrl,
    input  logic [AW-1:0]  bar,
    input  logic [DW-1:0]  bdr,
    input  logic           stb,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  data,
    input  logic           fetch,
    input  logic           write,
    input  logic           word,
    output logic           hit
);
    localparam int LW = DW / 2;

    logic kind_ok, size_ok, addr_ok, data_ok;

    always_comb begin
        unique case (ctrl.kind)
            TY_FETCH: kind_ok = fetch;
            TY_READ:  kind_ok = !fetch && !write;
            TY_WRITE: kind_ok = !fetch && write;
            default:  kind_ok = !fetch;
        endcase

        unique case (ctrl.size)
            SZ_BYTE: size_ok = !word;
            SZ_WORD: size_ok = word;
            default: size_ok = 1'b1;
        endcase

        if (word) addr_ok = (addr[AW-1:1] == bar[AW-1:1]);
        else      addr_ok = (addr == bar);

        if (!ctrl.dcmp)    data_ok = 1'b1;
        else if (!word)    data_ok = (data[DW-1:LW] == bdr[DW-1:LW]);
        else if (!addr[0]) data_ok = (data == bdr);
        else               data_ok = (data[LW-1:0] == bdr[LW-1:0]);

        hit = stb && kind_ok && size_ok && addr_ok && data_ok;
    end
endmodule

// File: rtl/abrk_regs.sv
module abrk_regs
    import abrk_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic           reg_re,
    input  logic [1:0]     reg_sel,
    input  logic [DW-1:0]  reg_wdata,
    input  logic           hit,
    output ctrl_t          ctrl,
    output logic [AW-1:0]  bar,
    output logic [DW-1:0]  bdr,
    output logic           flag,
    output logic           en,
    output logic           seen,
    output logic           irq,
    output logic [DW-1:0]  reg_rdata
);
    typedef struct packed {
        ctrl_t          ctrl;
        logic [AW-1:0]  bar;
        logic           flag;
        logic           en;
        logic           seen;
    } state_t;

    state_t        st_d, st_q;
    logic [DW-1:0] bdr_d, bdr_q;
    logic          wr_stat, clr_ok;

    always_comb begin
        st_d    = st_q;
        bdr_d   = bdr_q;
        wr_stat = reg_we && (reg_sel == SEL_STAT);
        clr_ok  = wr_stat && st_q.seen && !reg_wdata[STAT_FLAG_BIT];

        if (reg_we) begin
            unique case (reg_sel)
                SEL_CTRL: begin
                    st_d.ctrl      = ctrl_t'(reg_wdata[7:0]);
                    st_d.ctrl.rsvd = 3'b000;
                end
                SEL_STAT: st_d.en  = reg_wdata[STAT_EN_BIT];
                SEL_ADDR: st_d.bar = reg_wdata[AW-1:0];
                default:  bdr_d    = reg_wdata;
            endcase
        end

        if (reg_re && (reg_sel == SEL_STAT) && st_q.flag) st_d.seen = 1'b1;
        if (wr_stat)                                      st_d.seen = 1'b0;

        if (hit)         st_d.flag = 1'b1;
        else if (clr_ok) st_d.flag = 1'b0;

        unique case (reg_sel)
            SEL_CTRL: reg_rdata = DW'(st_q.ctrl);
            SEL_STAT: reg_rdata = DW'({st_q.flag, st_q.en});
            SEL_ADDR: reg_rdata = DW'(st_q.bar);
            default:  reg_rdata = bdr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        bdr_q <= bdr_d;
    end

    assign ctrl = st_q.ctrl;
    assign bar  = st_q.bar;
    assign bdr  = bdr_q;
    assign flag = st_q.flag;
    assign en   = st_q.en;
    assign seen = st_q.seen;
    assign irq  = st_q.flag && st_q.en;
endmodule

// File: rtl/abrk_unit.sv
module abrk_unit
    import abrk_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_stb,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_data,
    input  logic           bus_fetch,
    input  logic           bus_write,
    input  logic           bus_word,
    input  logic           reg_we,
    input  logic           reg_re,
    input  logic [1:0]     reg_sel,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic           brk_irq
);
    ctrl_t         ctrl_w;
    logic [AW-1:0] bar_w;
    logic [DW-1:0] bdr_w;
    logic          hit_w, flag_w, en_w, seen_w;

    abrk_match #(.AW(AW), .DW(DW)) u_match (
        .ctrl  (ctrl_w),
        .bar   (bar_w),
        .bdr   (bdr_w),
        .stb   (bus_stb),
        .addr  (bus_addr),
        .data  (bus_data),
        .fetch (bus_fetch),
        .write (bus_write),
        .word  (bus_word),
        .hit   (hit_w)
    );

    abrk_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .hit       (hit_w),
        .ctrl      (ctrl_w),
        .bar       (bar_w),
        .bdr       (bdr_w),
        .flag      (flag_w),
        .en        (en_w),
        .seen      (seen_w),
        .irq       (brk_irq),
        .reg_rdata (reg_rdata)
    );
endmodule

// File: rtl/abrk_chk.sv
module abrk_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_stb,
    input logic          bus_fetch,
    input logic          bus_word,
    input logic          reg_we,
    input logic [1:0]    reg_sel,
    input logic [DW-1:0] reg_wdata,
    input logic          brk_irq,
    input logic [7:0]    ctrl,
    input logic          hit,
    input logic          flag,
    input logic          en,
    input logic          seen
);
    logic zero_wr;
    assign zero_wr = reg_we && (reg_sel == 2'd1) && !reg_wdata[1];

    AST_NO_SET_WITHOUT_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !bus_stb) |=> !flag); // R9
    AST_UNREAD_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !seen) |=> flag); // R10
    AST_FLAG_HOLDS_NO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !zero_wr) |=> flag); // R10
    AST_HIT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag); // R11
    AST_FETCH_HIT_IS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ctrl[7:6] == 2'b10) |-> bus_fetch); // R13
    AST_BYTE_HIT_IS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ctrl[5:4] == 2'b01) |-> !bus_word); // R4
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_irq |-> en); // R12
endmodule

bind abrk_unit abrk_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_stb   (bus_stb),
    .bus_fetch (bus_fetch),
    .bus_word  (bus_word),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .brk_irq   (brk_irq),
    .ctrl      (ctrl_w),
    .hit       (hit_w),
    .flag      (flag_w),
    .en        (en_w),
    .seen      (seen_w)
);

// File: tb/sim_abrk_unit.sv
module sim_abrk_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_stb = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic        bus_fetch = 1'b0;
    logic        bus_write = 1'b0;
    logic        bus_word = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        brk_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    abrk_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_fetch(bus_fetch), .bus_write(bus_write),
        .bus_word(bus_word), .reg_we(reg_we), .reg_re(reg_re),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .brk_irq(brk_irq)
    );

    // {tag, ctrl, bar, bdr, addr, data, fetch, write, word, expected flag}
    localparam int NV = 23;
    localparam logic [83:0] VEC [NV] = '{
        {8'd13, 8'h80, 16'h025A, 16'h0000, 16'h025A, 16'h1111, 1'b1, 1'b0, 1'b1, 1'b1}, // R13 fetch
        {8'd13, 8'h80, 16'h025A, 16'h0000, 16'h025A, 16'h1111, 1'b0, 1'b0, 1'b1, 1'b0}, // R13 read
        {8'd3,  8'h00, 16'h1000, 16'h0000, 16'h1000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1}, // R3
        {8'd3,  8'h00, 16'h1000, 16'h0000, 16'h1000, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0}, // R3
        {8'd3,  8'h40, 16'h1000, 16'h0000, 16'h1000, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1}, // R3
        {8'd3,  8'hC0, 16'h1000, 16'h0000, 16'h1000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1}, // R3
        {8'd3,  8'hC0, 16'h1000, 16'h0000, 16'h1000, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0}, // R3
        {8'd4,  8'h10, 16'h1000, 16'h0000, 16'h1000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1}, // R4
        {8'd4,  8'h10, 16'h1000, 16'h0000, 16'h1000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0}, // R4
        {8'd4,  8'h20, 16'h1000, 16'h0000, 16'h1000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1}, // R4
        {8'd4,  8'h20, 16'h1000, 16'h0000, 16'h1000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0}, // R4
        {8'd5,  8'h00, 16'h1001, 16'h0000, 16'h1000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0}, // R5
        {8'd5,  8'h00, 16'h1001, 16'h0000, 16'h1000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1}, // R5
        {8'd5,  8'h00, 16'h1001, 16'h0000, 16'h1002, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0}, // R5
        {8'd6,  8'h18, 16'h2001, 16'hA53C, 16'h2001, 16'hA500, 1'b0, 1'b0, 1'b0, 1'b1}, // R6
        {8'd6,  8'h18, 16'h2000, 16'hA53C, 16'h2000, 16'hA5FF, 1'b0, 1'b0, 1'b0, 1'b1}, // R6
        {8'd6,  8'h18, 16'h2000, 16'hA53C, 16'h2000, 16'h3CA5, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
        {8'd7,  8'h28, 16'h3000, 16'h1234, 16'h3000, 16'h1234, 1'b0, 1'b0, 1'b1, 1'b1}, // R7
        {8'd7,  8'h28, 16'h3000, 16'h1234, 16'h3000, 16'h1235, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 R9
        {8'd7,  8'h28, 16'h3000, 16'h1234, 16'h3000, 16'h0034, 1'b0, 1'b0, 1'b1, 1'b0}, // R7
        {8'd7,  8'h28, 16'h3001, 16'h1234, 16'h3001, 16'hFF34, 1'b0, 1'b0, 1'b1, 1'b1}, // R7
        {8'd7,  8'h28, 16'h3001, 16'h1234, 16'h3001, 16'h1233, 1'b0, 1'b0, 1'b1, 1'b0}, // R7
        {8'd8,  8'h00, 16'h3000, 16'h1234, 16'h3000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1}  // R8
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] val);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] val);
        reg_re = 1'b1; reg_sel = sel;
        #1 val = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic cycle(input logic [15:0] a, input logic [15:0] d,
                         input logic f, input logic w, input logic wd, input logic s);
        bus_addr = a; bus_data = d; bus_fetch = f; bus_write = w; bus_word = wd;
        bus_stb = s;
        @(negedge clk);
        bus_stb = 1'b0;
    endtask

    task automatic clear_flag(input logic keep_en);
        logic [15:0] tmp;
        rd(2'd1, tmp);
        wr(2'd1, {15'd0, keep_en});
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); check("R1 ctrl", v, 16'h0000);
        rd(2'd2, v); check("R1 bar", v, 16'h0000);
        rd(2'd1, v); check("R1 status", v, 16'h0000);
        check("R1 irq", brk_irq, 0);

        // R2 register access
        wr(2'd2, 16'hBEEF); rd(2'd2, v); check("R2 bar", v, 16'hBEEF);
        wr(2'd3, 16'h5A69); rd(2'd3, v); check("R2 bdr", v, 16'h5A69);
        wr(2'd0, 16'hFFFF); rd(2'd0, v); check("R2 ctrl", v, 16'h00F8);

        // table of match vectors
        for (int i = 0; i < NV; i++) begin
            logic [83:0] e;
            e = VEC[i];
            wr(2'd0, {8'd0, e[75:68]});
            wr(2'd2, e[67:52]);
            wr(2'd3, e[51:36]);
            clear_flag(1'b0);
            cycle(e[35:20], e[19:4], e[3], e[2], e[1], 1'b1);
            rd(2'd1, v);
            checks++;
            if (v[1] !== e[0]) begin
                fails++;
                $display("FAIL R%0d vector %0d got=%0b exp=%0b", e[83:76], i, v[1], e[0]);
            end
        end

        // R9: matching fields without strobe
        wr(2'd0, 16'h0080); wr(2'd2, 16'h4000); clear_flag(1'b0);
        cycle(16'h4000, 16'h0, 1'b1, 1'b0, 1'b1, 1'b0);
        rd(2'd1, v); check("R9 no strobe", v[1], 0);

        // R12: flag set, enable off then on
        cycle(16'h4000, 16'h0, 1'b1, 1'b0, 1'b1, 1'b1);
        #1 check("R12 irq with en=0", brk_irq, 0);
        wr(2'd1, 16'h0001);
        #1 check("R12 irq with en=1", brk_irq, 1);

        // R10: zero write without a prior read leaves flag set
        wr(2'd1, 16'h0001);
        #1 check("R10 clear without read", brk_irq, 1);
        rd(2'd1, v);
        wr(2'd1, 16'h0003);
        #1 check("R10 write one keeps flag", brk_irq, 1);
        rd(2'd1, v);
        wr(2'd1, 16'h0001);
        #1 check("R10 valid clear", brk_irq, 0);
        wr(2'd1, 16'h0003);
        #1 check("R10 write one does not set", brk_irq, 0);

        // R11: match in the same cycle as a valid clear
        cycle(16'h4000, 16'h0, 1'b1, 1'b0, 1'b1, 1'b1);
        rd(2'd1, v); check("R11 flag set before race", v[1], 1);
        bus_addr = 16'h4000; bus_fetch = 1'b1; bus_word = 1'b1; bus_stb = 1'b1;
        reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 16'h0001;
        @(negedge clk);
        bus_stb = 1'b0; reg_we = 1'b0;
        #1 check("R11 match beats clear", brk_irq, 1);

        // R12: disabling drops the request
        wr(2'd1, 16'h0000);
        #1 check("R12 irq after disable", brk_irq, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule